// File: doc/BRIEF.md
# Bit-Plane Line Cache Writer

This block takes one cached line of eight pixels, each pixel holding a colour of up to eight bits, and stores it in planar framebuffer memory. Planar means one byte per bit plane, with each byte carrying the same colour bit of all eight pixels. Plane bytes are packed in pairs. Planes 0 and 1 sit in adjacent bytes, the next pair sits 16 bytes further on, and so on. A pending mask marks which pixels of the line were actually drawn. When only part of the line is pending, each plane byte is read back first, so that the pixels not pending keep their stored bits.

The block also serves single-pixel reads. It fetches each plane byte at a given base, picks the bit that belongs to the requested horizontal position, and rebuilds the colour. Flush requests and pixel read requests use valid/ready handshakes, and the rebuilt colour is returned on a valid/ready output.

The memory port is a plain byte port. A read issued in one cycle returns its data on `mem_rdata` in the following cycle. Every cycle with an access reports the configured access cost on `clk_add`, so that a clock accounting unit can add it up.

Top module: `pcf_flusher`

## Requirements
- R1: After reset the block is idle. `flush_ready` is 1, and `mem_req`, `flush_done`, `pix_valid`, `held_pend` and `clk_add` are all 0.
- R2: The depth code sets the plane count. Code 0 gives 2 planes, code 1 gives 4 planes, and codes 2 and 3 give 8 planes. A flush makes exactly one write per plane and no other write.
- R3: Planes are visited in ascending order. Plane n is accessed at base + ((n >> 1) * 16) + (n & 1), which gives offsets 0, 1, 16, 17, 32, 33, 48 and 49.
- R4: Pixel i occupies bits [8i+7:8i] of `flush_pix`, and pixel 0 is the leftmost. In the byte written for plane n, bit 7-i equals bit n of pixel i.
- R5: If `flush_pend` is not all ones, each plane is handled as a read of the plane address followed by a write to the same address. The read data is taken in the cycle after the read. The written byte takes new bits where the mask bit is 1 and stored bits where it is 0. Mask bit 7-i belongs to pixel i.
- R6: If `flush_pend` is all ones, the flush issues no reads. It writes every plane in consecutive cycles.
- R7: In every cycle with `mem_req` high, `clk_add` equals `access_cost`. In every other cycle, `clk_add` is 0.
- R8: After the last plane write, `flush_done` pulses high for exactly one cycle. In that cycle `held_pend` already reads 0.
- R9: A pixel read issues only reads, one per plane, in ascending order. Bit n of `pix_data` is bit 7-x of plane byte n. Bits at or above the plane count are 0.
- R10: Only one request is served at a time. When both requests are offered in the same cycle, the flush wins, and `rd_ready` stays low while `flush_valid` is high. `pix_valid` and `pix_data` stay unchanged until `pix_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_valid | input | 1 | Flush request offered |
| flush_ready | output | 1 | Flush request accepted when high with valid |
| flush_base | input | AW | Base address of plane 0 |
| flush_depth | input | 2 | Depth code (0: 2, 1: 4, 2/3: 8 planes) |
| flush_pix | input | 8*NPIX | Pixel colours, pixel i at [8i+7:8i] |
| flush_pend | input | NPIX | Pending mask, bit 7-i for pixel i |
| flush_done | output | 1 | One-cycle pulse when the flush finishes |
| held_pend | output | NPIX | Pending mask held for the flush in progress |
| rd_valid | input | 1 | Pixel read request offered |
| rd_ready | output | 1 | Pixel read accepted when high with valid |
| rd_base | input | AW | Base address of plane 0 for the read |
| rd_depth | input | 2 | Depth code for the read |
| rd_x | input | log2(NPIX) | Pixel position inside the byte, 0 is leftmost |
| pix_valid | output | 1 | Rebuilt colour available |
| pix_ready | input | 1 | Consumer takes the colour |
| pix_data | output | 8 | Rebuilt colour |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | NPIX | Write data |
| mem_rdata | input | NPIX | Read data, valid the cycle after a read |
| access_cost | input | CW | Cost of one memory access |
| clk_add | output | CW | Cost charged this cycle |

## Verification
Two functions can meet in one cycle: a flush request and a pixel read request raised on the same clock edge. The bench provokes this by offering both at one falling edge while the block is idle. The flush must be served first, and the read must wait with `rd_ready` low. The rebuilt colour returned afterwards must match the pixel just flushed, which shows that the read observed the new plane bytes and not the old ones.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

  localparam int PLANES_MAX = 8;
  localparam int PLW        = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRD,
    ST_FWR,
    ST_FDONE,
    ST_RRD,
    ST_RCAP,
    ST_ROUT
  } pcf_state_e;

  // Plane count for a depth code: 0 -> 2, 1 -> 4, otherwise 8
  function automatic logic [PLW:0] planes_for(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  // Planes come in pairs; each pair is 16 bytes past the previous one
  function automatic logic [5:0] plane_offset(input logic [PLW-1:0] n);
    return {n[2:1], 3'b000, n[0]};
  endfunction

endpackage

// File: rtl/pcf_plane_pack.sv
module pcf_plane_pack #(
  parameter int NPIX = 8,
  parameter int NPL  = 8
) (
  input  logic [NPIX*NPL-1:0]     pix,
  input  logic [$clog2(NPL)-1:0]  plane,
  output logic [NPIX-1:0]         byte_o
);
  // Leftmost pixel goes to the most significant bit of the plane byte
  for (genvar i = 0; i < NPIX; i++) begin : g_px
    logic [NPL-1:0] colour;
    assign colour             = pix[i*NPL +: NPL];
    assign byte_o[NPIX-1-i]   = colour[plane];
  end
endmodule

// File: rtl/pcf_rmw_merge.sv
module pcf_rmw_merge #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] fresh,
  input  logic [DW-1:0] stored,
  input  logic [DW-1:0] take,
  output logic [DW-1:0] merged
);
  // With take all ones the stored byte has no influence
  assign merged = (fresh & take) | (stored & ~take);
endmodule

// File: rtl/pcf_pixel_gather.sv
module pcf_pixel_gather #(
  parameter int NPIX = 8,
  parameter int NPL  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     capture,
  input  logic [$clog2(NPL)-1:0]   plane,
  input  logic [$clog2(NPIX)-1:0]  x,
  input  logic [NPIX-1:0]          rdata,
  output logic [NPL-1:0]           colour
);
  localparam int XW = $clog2(NPIX);

  logic [XW-1:0] bit_sel;
  assign bit_sel = XW'(NPIX - 1) - x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       colour <= '0;
    else if (clear)   colour <= '0;
    else if (capture) colour[plane] <= rdata[bit_sel];
  end
endmodule

// File: rtl/pcf_flusher.sv
module pcf_flusher
  import pcf_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 8,
  parameter int NPIX = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush_valid,
  output logic                          flush_ready,
  input  logic [AW-1:0]                 flush_base,
  input  logic [1:0]                    flush_depth,
  input  logic [NPIX*PLANES_MAX-1:0]    flush_pix,
  input  logic [NPIX-1:0]               flush_pend,
  output logic                          flush_done,
  output logic [NPIX-1:0]               held_pend,
  input  logic                          rd_valid,
  output logic                          rd_ready,
  input  logic [AW-1:0]                 rd_base,
  input  logic [1:0]                    rd_depth,
  input  logic [$clog2(NPIX)-1:0]       rd_x,
  output logic                          pix_valid,
  input  logic                          pix_ready,
  output logic [PLANES_MAX-1:0]         pix_data,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [AW-1:0]                 mem_addr,
  output logic [NPIX-1:0]               mem_wdata,
  input  logic [NPIX-1:0]               mem_rdata,
  input  logic [CW-1:0]                 access_cost,
  output logic [CW-1:0]                 clk_add
);
  localparam int XW = $clog2(NPIX);

  pcf_state_e                   st;
  logic [PLW-1:0]               plane_q;
  logic [PLW:0]                 nplanes_q;
  logic [AW-1:0]                base_q;
  logic [NPIX*PLANES_MAX-1:0]   pix_q;
  logic [NPIX-1:0]              pend_q;
  logic [XW-1:0]                x_q;
  logic                         full_q;

  logic                         accept_fl;
  logic                         accept_rd;
  logic                         last_plane;
  logic [NPIX-1:0]              packed_b;

  assign flush_ready = (st == ST_IDLE);
  assign rd_ready    = (st == ST_IDLE) && !flush_valid;
  assign accept_fl   = flush_valid && flush_ready;
  assign accept_rd   = rd_valid && rd_ready;
  assign last_plane  = ({1'b0, plane_q} == (nplanes_q - 4'd1));

  assign mem_req     = (st == ST_FRD) || (st == ST_FWR) || (st == ST_RRD);
  assign mem_we      = (st == ST_FWR);
  assign mem_addr    = base_q + AW'(plane_offset(plane_q));
  assign clk_add     = mem_req ? access_cost : '0;
  assign flush_done  = (st == ST_FDONE);
  assign pix_valid   = (st == ST_ROUT);
  assign held_pend   = pend_q;

  pcf_plane_pack #(.NPIX(NPIX), .NPL(PLANES_MAX)) u_pack (
    .pix    (pix_q),
    .plane  (plane_q),
    .byte_o (packed_b)
  );

  pcf_rmw_merge #(.DW(NPIX)) u_merge (
    .fresh  (packed_b),
    .stored (mem_rdata),
    .take   (pend_q),
    .merged (mem_wdata)
  );

  pcf_pixel_gather #(.NPIX(NPIX), .NPL(PLANES_MAX)) u_gather (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept_rd),
    .capture (st == ST_RCAP),
    .plane   (plane_q),
    .x       (x_q),
    .rdata   (mem_rdata),
    .colour  (pix_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      plane_q   <= '0;
      nplanes_q <= '0;
      base_q    <= '0;
      pix_q     <= '0;
      pend_q    <= '0;
      x_q       <= '0;
      full_q    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept_fl) begin
            base_q    <= flush_base;
            pix_q     <= flush_pix;
            pend_q    <= flush_pend;
            full_q    <= (flush_pend == '1);
            nplanes_q <= planes_for(flush_depth);
            plane_q   <= '0;
            st        <= (flush_pend == '1) ? ST_FWR : ST_FRD;
          end else if (accept_rd) begin
            base_q    <= rd_base;
            x_q       <= rd_x;
            nplanes_q <= planes_for(rd_depth);
            plane_q   <= '0;
            st        <= ST_RRD;
          end
        end
        ST_FRD: st <= ST_FWR;
        ST_FWR: begin
          if (last_plane) begin
            pend_q <= '0;
            st     <= ST_FDONE;
          end else begin
            plane_q <= plane_q + 3'd1;
            st      <= full_q ? ST_FWR : ST_FRD;
          end
        end
        ST_FDONE: st <= ST_IDLE;
        ST_RRD:   st <= ST_RCAP;
        ST_RCAP: begin
          if (last_plane) begin
            st <= ST_ROUT;
          end else begin
            plane_q <= plane_q + 3'd1;
            st      <= ST_RRD;
          end
        end
        ST_ROUT: if (pix_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pcf_checker.sv
module pcf_checker #(
  parameter int AW   = 16,
  parameter int CW   = 8,
  parameter int NPIX = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush_valid,
  input logic            flush_ready,
  input logic [AW-1:0]   flush_base,
  input logic [NPIX-1:0] flush_pend,
  input logic            flush_done,
  input logic [NPIX-1:0] held_pend,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic            pix_valid,
  input logic            pix_ready,
  input logic [7:0]      pix_data,
  input logic            mem_req,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic [CW-1:0]   clk_add
);
  logic            in_fl;
  logic            in_rd;
  logic [AW-1:0]   cap_base;
  logic [NPIX-1:0] cap_pend;
  logic [AW-1:0]   off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_fl    <= 1'b0;
      in_rd    <= 1'b0;
      cap_base <= '0;
      cap_pend <= '0;
    end else begin
      if (flush_valid && flush_ready) begin
        in_fl    <= 1'b1;
        cap_base <= flush_base;
        cap_pend <= flush_pend;
      end else if (flush_done) begin
        in_fl <= 1'b0;
      end
      if (rd_valid && rd_ready)        in_rd <= 1'b1;
      else if (pix_valid && pix_ready) in_rd <= 1'b0;
    end
  end

  assign off = mem_addr - cap_base;

  // R3: flush accesses land only on the paired plane offsets
  a_r3_plane_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fl && mem_req) |-> ((off & ~AW'(49)) == '0));

  // R6: a fully pending line never reads back
  a_r6_no_read_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fl && cap_pend == '1) |-> !(mem_req && !mem_we));

  // R7: nothing is charged without an access
  a_r7_cost_only_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> (clk_add == '0));

  // R8: mask is cleared when done is reported
  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> (held_pend == '0));

  // R8: done lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  // R9: pixel reads never write
  a_r9_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rd && mem_req) |-> !mem_we);

  // R10: result is held until taken
  a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));

  // R10: flush has priority over a pixel read
  a_r10_flush_first: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !rd_ready);

endmodule

bind pcf_flusher pcf_checker #(.AW(AW), .CW(CW), .NPIX(NPIX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush_valid (flush_valid),
  .flush_ready (flush_ready),
  .flush_base  (flush_base),
  .flush_pend  (flush_pend),
  .flush_done  (flush_done),
  .held_pend   (held_pend),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .pix_valid   (pix_valid),
  .pix_ready   (pix_ready),
  .pix_data    (pix_data),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .clk_add     (clk_add)
);

// File: tb/sim_pcf_flusher.sv
`timescale 1ns/1ps
module sim_pcf_flusher;

  localparam int AW = 16;
  localparam int CW = 8;

  typedef struct {
    bit          we;
    logic [15:0] addr;
    logic [7:0]  data;
    string       tag;
  } acc_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        f_valid = 1'b0;
  logic [15:0] f_base = '0;
  logic [1:0]  f_depth = '0;
  logic [63:0] f_pix = '0;
  logic [7:0]  f_pend = '0;
  logic        r_valid = 1'b0;
  logic [15:0] r_base = '0;
  logic [1:0]  r_depth = '0;
  logic [2:0]  r_x = '0;
  logic        p_ready = 1'b1;
  logic [7:0]  cost = 8'd5;
  logic [7:0]  mem_rdata = '0;

  logic        flush_ready, flush_done, rd_ready, pix_valid;
  logic        mem_req, mem_we;
  logic [7:0]  held_pend, pix_data, mem_wdata, clk_add;
  logic [15:0] mem_addr;

  logic [7:0]  bmem   [0:255];
  logic [7:0]  shadow [0:255];
  acc_t        mq[$];
  logic [7:0]  pq[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;
  logic [7:0]  last_pix;

  always #10 clk = ~clk;

  pcf_flusher #(.AW(AW), .CW(CW), .NPIX(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .flush_valid(f_valid), .flush_ready(flush_ready), .flush_base(f_base),
    .flush_depth(f_depth), .flush_pix(f_pix), .flush_pend(f_pend),
    .flush_done(flush_done), .held_pend(held_pend),
    .rd_valid(r_valid), .rd_ready(rd_ready), .rd_base(r_base),
    .rd_depth(r_depth), .rd_x(r_x),
    .pix_valid(pix_valid), .pix_ready(p_ready), .pix_data(pix_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .access_cost(cost), .clk_add(clk_add)
  );

  // Byte memory: read data appears the cycle after the request
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr[7:0]];
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int nplanes(input logic [1:0] d);
    return (d == 2'd0) ? 2 : (d == 2'd1) ? 4 : 8;
  endfunction

  function automatic logic [15:0] offs(input int p);
    return 16'(((p >> 1) * 16) + (p & 1));
  endfunction

  function automatic logic [63:0] mkpix(input logic [7:0] a, b, c, d, e, f, g, h);
    return {h, g, f, e, d, c, b, a};
  endfunction

  task automatic exp_flush(input logic [15:0] base, input logic [1:0] d,
                           input logic [63:0] pix, input logic [7:0] pend);
    for (int p = 0; p < nplanes(d); p++) begin
      logic [15:0] a;
      logic [7:0]  nb;
      logic [7:0]  wb;
      acc_t        it;
      a = base + offs(p);
      for (int i = 0; i < 8; i++) nb[7-i] = pix[8*i + p];
      if (pend != 8'hFF) begin
        it.we = 1'b0; it.addr = a; it.data = '0; it.tag = "R5 read-back";
        mq.push_back(it);
      end
      wb = (nb & pend) | (shadow[a[7:0]] & ~pend);
      it.we = 1'b1; it.addr = a; it.data = wb;
      it.tag = (pend == 8'hFF) ? "R4/R6 plane write" : "R5 merged write";
      mq.push_back(it);
      shadow[a[7:0]] = wb;
    end
  endtask

  task automatic exp_read(input logic [15:0] base, input logic [1:0] d, input logic [2:0] x);
    logic [7:0] col;
    col = '0;
    for (int p = 0; p < nplanes(d); p++) begin
      acc_t        it;
      logic [15:0] a;
      logic [7:0]  sb;
      a = base + offs(p);
      it.we = 1'b0; it.addr = a; it.data = '0; it.tag = "R9 plane read";
      mq.push_back(it);
      sb = shadow[a[7:0]];
      col[p] = sb[7-x];
    end
    pq.push_back(col);
  endtask

  task automatic drive_flush(input logic [15:0] base, input logic [1:0] d,
                             input logic [63:0] pix, input logic [7:0] pend, input bit solo);
    @(negedge clk);
    f_valid = 1'b1; f_base = base; f_depth = d; f_pix = pix; f_pend = pend;
    #1;
    while (!flush_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    f_valid = 1'b0;
    #1;
    while (!flush_done) begin @(negedge clk); #1; end
    chk(held_pend == 8'h00, "R8 mask cleared at done", 32'(held_pend), 0);
    if (solo) chk(mq.size() == 0, "R2 all plane writes issued", mq.size(), 0);
    @(negedge clk); #1;
    chk(!flush_done, "R8 done is one cycle", 32'(flush_done), 0);
  endtask

  task automatic drive_read(input logic [15:0] base, input logic [1:0] d,
                            input logic [2:0] x, input bit hold);
    @(negedge clk);
    r_valid = 1'b1; r_base = base; r_depth = d; r_x = x;
    if (hold) p_ready = 1'b0;
    #1;
    while (!rd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    r_valid = 1'b0;
    #1;
    while (!pix_valid) begin @(negedge clk); #1; end
    last_pix = pix_data;
    if (hold) begin
      repeat (3) begin
        @(negedge clk); #1;
        chk(pix_valid && pix_data == last_pix, "R10 result held while not taken",
            32'(pix_data), 32'(last_pix));
      end
      @(negedge clk);
      p_ready = 1'b1;
      #1;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Monitor: compares every access and every returned colour
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && !finished) begin
        if (mem_req) begin
          if (mq.size() == 0) begin
            chk(1'b0, "R2 unexpected access", 32'(mem_addr), 0);
          end else begin
            acc_t e;
            e = mq.pop_front();
            chk(mem_addr == e.addr, {"R3 address of ", e.tag}, 32'(mem_addr), 32'(e.addr));
            chk(mem_we == e.we, {"R5/R6 access kind of ", e.tag}, 32'(mem_we), 32'(e.we));
            if (e.we) chk(mem_wdata == e.data, {"R4/R5 data of ", e.tag}, 32'(mem_wdata), 32'(e.data));
            chk(clk_add == cost, "R7 access cost", 32'(clk_add), 32'(cost));
          end
        end else if (clk_add != 8'd0) begin
          chk(1'b0, "R7 cost without access", 32'(clk_add), 0);
        end
        if (pix_valid && p_ready) begin
          if (pq.size() == 0) chk(1'b0, "R9 unexpected colour", 32'(pix_data), 0);
          else begin
            logic [7:0] c;
            c = pq.pop_front();
            chk(pix_data == c, "R9 rebuilt colour", 32'(pix_data), 32'(c));
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    #2000000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog actual=hung expected=progress");
      summary();
    end
  end

  initial begin
    logic [63:0] pa, pb, pc, pd;
    for (int i = 0; i < 256; i++) begin
      bmem[i]   = 8'(i * 37 + 5);
      shadow[i] = 8'(i * 37 + 5);
    end
    pa = mkpix(8'h01, 8'h02, 8'h03, 8'h00, 8'h01, 8'h02, 8'h03, 8'h01);
    pb = mkpix(8'h0F, 8'h05, 8'h0A, 8'h03, 8'h0C, 8'h00, 8'h09, 8'h06);
    pc = mkpix(8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81, 8'h7E, 8'h12, 8'hC9);
    pd = mkpix(8'h5A, 8'hE1, 8'h0F, 8'hF0, 8'h33, 8'hCC, 8'h99, 8'h66);

    repeat (3) @(negedge clk);
    #1;
    chk(flush_ready, "R1 ready in reset", 32'(flush_ready), 1);
    chk(!mem_req && !flush_done && !pix_valid, "R1 quiet outputs in reset",
        {29'd0, mem_req, flush_done, pix_valid}, 0);
    chk(held_pend == 0 && clk_add == 0, "R1 mask and cost zero", 32'({held_pend, clk_add}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(flush_ready && !mem_req, "R1 idle after reset", 32'({flush_ready, mem_req}), 2);

    // R2/R6: two planes, full mask
    exp_flush(16'd200, 2'd0, pa, 8'hFF);
    drive_flush(16'd200, 2'd0, pa, 8'hFF, 1'b1);

    // R5: four planes, half pending, different cost
    cost = 8'd3;
    exp_flush(16'd0, 2'd1, pb, 8'h0F);
    drive_flush(16'd0, 2'd1, pb, 8'h0F, 1'b1);

    // R5: nothing pending keeps stored bytes, eight planes
    cost = 8'd11;
    exp_flush(16'd20, 2'd2, pc, 8'h00);
    drive_flush(16'd20, 2'd2, pc, 8'h00, 1'b1);

    // R2/R4: depth code 3, full mask, then rebuild pixels
    exp_flush(16'd100, 2'd3, pc, 8'hFF);
    drive_flush(16'd100, 2'd3, pc, 8'hFF, 1'b1);
    exp_read(16'd100, 2'd3, 3'd0);
    drive_read(16'd100, 2'd3, 3'd0, 1'b0);
    chk(last_pix == 8'hA5, "R9 leftmost pixel round trip", 32'(last_pix), 32'hA5);
    exp_read(16'd100, 2'd3, 3'd7);
    drive_read(16'd100, 2'd3, 3'd7, 1'b1);
    chk(last_pix == 8'hC9, "R9 rightmost pixel round trip", 32'(last_pix), 32'hC9);

    // R9: two planes only, upper colour bits zero
    exp_read(16'd100, 2'd0, 3'd2);
    drive_read(16'd100, 2'd0, 3'd2, 1'b0);
    chk(last_pix == 8'h03, "R9 upper bits zero for two planes", 32'(last_pix), 32'h03);

    // R10: flush and read offered in the same cycle
    cost = 8'd1;
    exp_flush(16'd150, 2'd2, pd, 8'hF0);
    exp_read(16'd150, 2'd2, 3'd1);
    fork
      drive_flush(16'd150, 2'd2, pd, 8'hF0, 1'b0);
      drive_read(16'd150, 2'd2, 3'd1, 1'b0);
    join
    chk(last_pix == 8'hE1, "R10 read sees flushed pixel", 32'(last_pix), 32'hE1);

    repeat (4) @(negedge clk);
    #1;
    chk(mq.size() == 0 && pq.size() == 0, "R2 no missing accesses", mq.size() + pq.size(), 0);
    summary();
  end

endmodule